// File: doc/BRIEF.md
# Paged Address Translator with Stored Maps

This block sits between a CPU with a 16-bit address bus and a larger physical memory. The CPU space is cut into sixteen 4K pages. A small fast mapping RAM holds 256 complete maps, each with sixteen 8-bit page entries. An 8-bit select latch picks which map is live. The top four CPU address bits pick an entry in that map, and the entry takes the place of those four bits. The result is a 20-bit physical address covering 1M.

Software loads the maps with I/O writes. One port sets the select latch. A second port writes an entry, and the upper I/O address nibble picks which entry of the currently selected map is written. A third port only turns translation on. Because loading uses I/O-request cycles and the memory enable follows only memory-request cycles, filling a map never touches expanded memory. After reset the mapping RAM holds no defined data, so the translated page is forced to all ones until translation is turned on. A region shared by every map is made by storing the same entry for that page in each map.

The `BANKS` parameter adds parallel map memories. Each one is loaded through its own entry port and adds 8 more physical address bits.

Top module: `page_mapper`

## Requirements
- R1: After reset, translation is off and every physical page bit reads 1 for any CPU address, until a write reaches the select port or the enable port.
- R2: Physical address bits 11:0 always equal CPU address bits 11:0.
- R3: An I/O write (iorq and wr high at a clock edge) to port 0x40, taken from CPU address bits 7:0, loads the data byte into the select latch and turns translation on, starting with the next cycle.
- R4: An I/O write to port 0x42 stores the data byte as entry cpu_addr[15:12] of the currently selected map. Once translation is on, that byte appears as physical bits 19:12 for CPU addresses in that page.
- R5: One write to port 0x40 switches all sixteen pages to the entries of the newly selected map.
- R6: A page that holds the same entry in every map translates to the same physical page whichever map is selected, shown here with page 0xF.
- R7: An I/O write to port 0x41 turns translation on and leaves the select latch unchanged.
- R8: Cycles with wr high and iorq low, including memory-request cycles, change neither the select latch nor any map entry.
- R9: mem_en is high exactly when mreq is high and iorq is low, so mem_en is always low during I/O cycles.
- R10: Translation is combinational. A new CPU address shows its physical address in the same cycle, with no wait state.
- R11: I/O writes to ports other than the select, enable and entry ports leave the translation unchanged.
- R12: With BANKS=2, port 0x43 loads a second map memory in the same way as port 0x42. Physical bits 27:20 come from that second memory and bits 19:12 from the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address; bits 7:0 are the I/O port during I/O cycles |
| cpu_data | input | 8 | CPU write data |
| mreq | input | 1 | Memory request |
| iorq | input | 1 | I/O request |
| wr | input | 1 | Write strobe |
| phys_addr | output | 12+8*BANKS | Translated physical address |
| mem_en | output | 1 | Enable for expanded memory |

## Verification
The assertions assume that every I/O write is held for exactly one clock edge, and that address and data are stable across that edge. Under that assumption one bus cycle is one register update, and the select latch can change only on the cycle after a write to the select port. The bench changes its inputs on the falling clock edge and holds each I/O write for one rising edge. It drives iorq together with mreq only once, on purpose, to check the gating of mem_en.

// File: rtl/page_mapper_pkg.sv
package page_mapper_pkg;
    localparam int CPU_AW    = 16;
    localparam int OFS_W     = 12;
    localparam int IDX_W     = CPU_AW - OFS_W;
    localparam int DATA_W    = 8;
    localparam int SEL_W     = 8;
    localparam int ENTRY_W   = 8;
    localparam int PORT_W    = 8;
    localparam int N_MAPS    = 1 << SEL_W;
    localparam int N_IDX     = 1 << IDX_W;
    localparam int RAM_AW    = SEL_W + IDX_W;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             en;
    } ctrl_t;
endpackage

// File: rtl/page_mapper_ctrl.sv
module page_mapper_ctrl
    import page_mapper_pkg::*;
#(
    parameter logic [PORT_W-1:0] SEL_PORT = 8'h40,
    parameter logic [PORT_W-1:0] EN_PORT  = 8'h41
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic [PORT_W-1:0] io_port,
    input  logic [DATA_W-1:0] data,
    output logic [SEL_W-1:0]  sel_q,
    output logic              en_q
);
    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (io_wr && io_port == SEL_PORT) begin
            ctrl_d.sel = data[SEL_W-1:0];
            ctrl_d.en  = 1'b1;
        end else if (io_wr && io_port == EN_PORT) begin
            ctrl_d.en  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign sel_q = ctrl_q.sel;
    assign en_q  = ctrl_q.en;
endmodule

// File: rtl/page_mapper_bank.sv
module page_mapper_bank
    import page_mapper_pkg::*;
(
    input  logic               clk,
    input  logic               we,
    input  logic [RAM_AW-1:0]  addr,
    input  logic [ENTRY_W-1:0] wdata,
    output logic [ENTRY_W-1:0] rdata
);
    // No reset: contents are undefined after power-up, masked by the enable flag.
    logic [ENTRY_W-1:0] map_mem [N_MAPS*N_IDX];

    always_ff @(posedge clk) begin
        if (we) begin
            map_mem[addr] <= wdata;
        end
    end

    assign rdata = map_mem[addr];
endmodule

// File: rtl/page_mapper.sv
module page_mapper
    import page_mapper_pkg::*;
#(
    parameter int                BANKS      = 1,
    parameter logic [PORT_W-1:0] SEL_PORT   = 8'h40,
    parameter logic [PORT_W-1:0] EN_PORT    = 8'h41,
    parameter logic [PORT_W-1:0] ENTRY_PORT = 8'h42,
    localparam int               PHYS_W     = OFS_W + ENTRY_W * BANKS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic              mreq,
    input  logic              iorq,
    input  logic              wr,
    output logic [PHYS_W-1:0] phys_addr,
    output logic              mem_en
);
    logic                       io_wr;
    logic [PORT_W-1:0]          io_port;
    logic [SEL_W-1:0]           sel_q;
    logic                       en_q;
    logic [RAM_AW-1:0]          ram_addr;
    logic [ENTRY_W*BANKS-1:0]   raw_page;

    assign io_wr    = iorq & wr;
    assign io_port  = cpu_addr[PORT_W-1:0];
    assign ram_addr = {sel_q, cpu_addr[CPU_AW-1:OFS_W]};

    page_mapper_ctrl #(
        .SEL_PORT (SEL_PORT),
        .EN_PORT  (EN_PORT)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .io_wr   (io_wr),
        .io_port (io_port),
        .data    (cpu_data),
        .sel_q   (sel_q),
        .en_q    (en_q)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        localparam logic [PORT_W-1:0] MY_PORT = ENTRY_PORT + PORT_W'(b);
        logic bank_we;
        assign bank_we = io_wr && (io_port == MY_PORT);
        page_mapper_bank u_bank (
            .clk   (clk),
            .we    (bank_we),
            .addr  (ram_addr),
            .wdata (cpu_data[ENTRY_W-1:0]),
            .rdata (raw_page[b*ENTRY_W +: ENTRY_W])
        );
    end

    assign phys_addr = {(en_q ? raw_page : {(ENTRY_W*BANKS){1'b1}}),
                        cpu_addr[OFS_W-1:0]};
    assign mem_en    = mreq & ~iorq;
endmodule

// File: rtl/page_mapper_chk.sv
module page_mapper_chk
    import page_mapper_pkg::*;
#(
    parameter int                PHYS_W   = 20,
    parameter logic [PORT_W-1:0] SEL_PORT = 8'h40
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CPU_AW-1:0] cpu_addr,
    input logic [DATA_W-1:0] cpu_data,
    input logic              mreq,
    input logic              iorq,
    input logic              wr,
    input logic [PHYS_W-1:0] phys_addr,
    input logic              mem_en,
    input logic [SEL_W-1:0]  sel_q,
    input logic              en_q
);
    p_off_forced_ones_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (&phys_addr[PHYS_W-1:OFS_W]));

    p_sel_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (iorq && wr && cpu_addr[PORT_W-1:0] == SEL_PORT)
        |=> (sel_q == $past(cpu_data[SEL_W-1:0])) && en_q);

    p_en_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> en_q);

    p_no_io_no_sel_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(iorq && wr) |=> $stable(sel_q));

    p_io_blocks_mem_r9: assert property (@(posedge clk) disable iff (!rst_n)
        iorq |-> !mem_en);
endmodule

bind page_mapper page_mapper_chk #(
    .PHYS_W   (PHYS_W),
    .SEL_PORT (SEL_PORT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_data  (cpu_data),
    .mreq      (mreq),
    .iorq      (iorq),
    .wr        (wr),
    .phys_addr (phys_addr),
    .mem_en    (mem_en),
    .sel_q     (sel_q),
    .en_q      (en_q)
);

// File: tb/page_mapper_bench.sv
`timescale 1ns/1ps
module page_mapper_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        mreq = 1'b0, iorq = 1'b0, wr = 1'b0;
    logic [19:0] phys;
    logic [27:0] phys_w;
    logic        mem_en, mem_en_w;
    int          total = 0;
    int          bad = 0;

    always #10 clk = ~clk;

    page_mapper u_page_mapper (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .mreq(mreq), .iorq(iorq), .wr(wr), .phys_addr(phys), .mem_en(mem_en));

    page_mapper #(.BANKS(2)) u_page_mapper_wide (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .mreq(mreq), .iorq(iorq), .wr(wr), .phys_addr(phys_w), .mem_en(mem_en_w));

    // {op, addr, data, expected page}; op 0 = I/O write, 1 = translate check
    localparam int NV = 19;
    localparam logic [33:0] VEC [NV] = '{
        {2'd0, 16'h0040, 8'h01, 8'h00},
        {2'd0, 16'h0042, 8'h10, 8'h00},
        {2'd0, 16'h5042, 8'h15, 8'h00},
        {2'd0, 16'hF042, 8'hFF, 8'h00},
        {2'd0, 16'h0040, 8'h02, 8'h00},
        {2'd0, 16'h0042, 8'h20, 8'h00},
        {2'd0, 16'h5042, 8'h25, 8'h00},
        {2'd0, 16'hF042, 8'hFF, 8'h00},
        {2'd1, 16'h0123, 8'h00, 8'h20},
        {2'd1, 16'h5ABC, 8'h00, 8'h25},
        {2'd1, 16'hFFFF, 8'h00, 8'hFF},
        {2'd0, 16'h0040, 8'h01, 8'h00},
        {2'd1, 16'h0123, 8'h00, 8'h10},
        {2'd1, 16'h5000, 8'h00, 8'h15},
        {2'd1, 16'hF456, 8'h00, 8'hFF},
        {2'd0, 16'h5044, 8'h77, 8'h00},
        {2'd1, 16'h5000, 8'h00, 8'h15},
        {2'd0, 16'h0040, 8'h02, 8'h00},
        {2'd1, 16'h5FFF, 8'h00, 8'h25}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; iorq = 1'b1; wr = 1'b1; mreq = 1'b0;
        @(negedge clk);
        iorq = 1'b0; wr = 1'b0;
    endtask

    // R10: address change and sample in the same low clock phase, no edge between
    task automatic xlate(input logic [15:0] a, input logic [7:0] pg, input string req);
        @(negedge clk);
        cpu_addr = a; mreq = 1'b1;
        #2;
        check(req, {24'd0, phys[19:12]}, {24'd0, pg});
        check("R2 offset", {20'd0, phys[11:0]}, {20'd0, a[11:0]});
        check("R9 mem_en on mreq", {31'd0, mem_en}, 32'd1);
        mreq = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    initial begin : watchdog
        #2000000;
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1 power-up default
        xlate(16'h0000, 8'hFF, "R1 reset page0");
        xlate(16'h5123, 8'hFF, "R1 reset page5");

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][33:32] == 2'd0) io_write(VEC[i][31:16], VEC[i][15:8]);
            else xlate(VEC[i][31:16], VEC[i][7:0],
                       "R4 R5 R6 R11 table translate");
        end

        // R8: memory-request write to an address whose low byte is the select port
        @(negedge clk);
        cpu_addr = 16'h5040; cpu_data = 8'h09; mreq = 1'b1; wr = 1'b1;
        #2 check("R9 mem_en in mem write", {31'd0, mem_en}, 32'd1);
        @(negedge clk); mreq = 1'b0; wr = 1'b0;
        xlate(16'h5000, 8'h25, "R8 mem write ignored");

        // R9: I/O request gates mem_en even with mreq high
        @(negedge clk);
        cpu_addr = 16'h0050; iorq = 1'b1; mreq = 1'b1;
        #2 check("R9 mem_en low in io", {31'd0, mem_en}, 32'd0);
        @(negedge clk); iorq = 1'b0; mreq = 1'b0;

        // R7: enable port leaves select 0, entry loaded while off
        do_reset();
        io_write(16'h3042, 8'h33);
        xlate(16'h3210, 8'hFF, "R1 still off after entry write");
        io_write(16'h0041, 8'h99);
        xlate(16'h3210, 8'h33, "R7 enable keeps map 0");

        // R12: two banks
        do_reset();
        @(negedge clk); cpu_addr = 16'h1234; #2;
        check("R1 wide off", {4'd0, phys_w}, {4'd0, 28'hFFFF234});
        io_write(16'h0040, 8'h05);
        io_write(16'h1042, 8'hAB);
        io_write(16'h1043, 8'hCD);
        @(negedge clk); cpu_addr = 16'h1234; #2;
        check("R12 wide translate", {4'd0, phys_w}, {4'd0, 28'hCDAB234});
        // R3 select latch reached via translation of the same page in map 5
        check("R3 narrow map5 page1", {24'd0, phys[19:12]}, 32'h000000AB);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule